// File: doc/BRIEF.md
# Platform Trust-State Controller

This block tracks whether a reconfigurable device is in a trusted condition in which it can report its own configuration. It owns the measurement state that an attestation reports. One register holds a running digest of the static region, and it accumulates every certified change. A second register holds the digest of the reconfigurable region, and each new configuration replaces it. A small bank of platform registers accumulates software measurements. Digests arrive already computed. Hashing, signing and transport to an external security chip are done elsewhere.

Events arrive as single-cycle one-hot pulses on `evt_code`. Each pulse carries a digest, a certification flag for static changes, and a platform register index for software measurements. The block has four states: empty fabric, booting, operational (reporting) and locked. Two actions lock the block: an uncertified static change, or opening a configuration port that is not monitored. Once locked, the block stays locked until a power-off and a fresh boot. An event that does not apply in the current state has no effect on the state or the registers, and it increments a saturating error counter. The attestation outputs carry data only while the trust-enable flag is high.

Top module: `trust_state_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it is released, `trust_state` is 0 (empty fabric), `tpm_en` is 0, `att_valid` is 0, all attestation data is zero and `err_count` is 0. The state encoding is: 0 empty fabric, 1 booting, 2 operational, 3 locked.
- R2: Event bits are: bit 0 power-on, bit 1 load complete, bit 2 static reconfiguration, bit 3 reconfigurable-region reconfiguration, bit 4 unmonitored port enable, bit 5 software measurement, bit 6 power-off. Power-on moves state 0 to 1. Load complete moves state 1 to 2 and sets three things: static register = H(0, d), reconfigurable register = d, and all platform registers = 0. H(a, d) = ((a rotated left by ROT) XOR d) + MIX_K, modulo 2^DW.
- R3: A static reconfiguration in state 2 with `evt_certified` high sets static register = H(static register, d). The state stays 2.
- R4: A reconfigurable-region reconfiguration in state 2 overwrites the reconfigurable register with d, with no accumulation, and clears every platform register.
- R5: A static reconfiguration in state 2 with `evt_certified` low moves the block to state 3 and drops `tpm_en` on the next cycle.
- R6: An unmonitored port enable in state 2 moves the block to state 3.
- R7: In state 3 only power-off is applicable. Every other event, including a reconfigurable-region reconfiguration and power-on, leaves the state at 3.
- R8: A software measurement in state 2 sets platform register[`evt_pcr_sel`] = H(old value, d). The other platform registers are unchanged.
- R9: Power-off in any state moves the block to state 0 and clears all registers. Power-off in state 0 is not an error.
- R10: `att_valid` equals `tpm_en`, which is high only in state 2. While it is low, `att_static`, `att_recon` and `att_pcr` all read zero. While it is high, they show the two hardware registers and the platform register chosen by `att_pcr_sel`.
- R11: An event that does not apply in the current state, or a code with more than one bit set, changes neither state nor registers, and increments `err_count`. `err_count` saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_code | input | 7 | One-hot event pulse; zero means idle |
| evt_certified | input | 1 | Static reconfiguration carries a certified image |
| evt_digest | input | DW | Digest that comes with the event |
| evt_pcr_sel | input | PSW | Platform register targeted by a software measurement |
| att_pcr_sel | input | PSW | Platform register shown on `att_pcr` |
| tpm_en | output | 1 | Trust enable; high only while operational |
| trust_state | output | 2 | Current trust state |
| att_valid | output | 1 | Attestation outputs carry data |
| att_static | output | DW | Static-region register, or zero |
| att_recon | output | DW | Reconfigurable-region register, or zero |
| att_pcr | output | DW | Selected platform register, or zero |
| err_count | output | EW | Saturating count of inapplicable events |

## Verification
The bench drives two certified static changes in a row. A design that overwrote the static register instead of accumulating would show only the last digest. It then drives repeated software measurements into one platform register and later a reconfigurable-region change. A design that forgot to clear the platform bank, or that accumulated into the reconfigurable register, would show stale values. Once locked, the bench sends a reconfigurable-region change and a power-on. A design that let either event restore trust would raise `tpm_en`. The bench also sends multi-bit codes, power-off while booting, a reset in the middle of a run and more than 255 bad events. A counter that wrapped, or a design that acted on a multi-bit code, would show up on `err_count` and on the attestation outputs.

// File: rtl/trust_pkg.sv
// Shared definitions for the trust-state controller.
// Event bit positions, the state encoding and the measurement control strobes.
package trust_pkg;
    localparam int NUM_EVT        = 7;
    localparam int EV_PWR_ON      = 0;
    localparam int EV_LOADED      = 1;
    localparam int EV_RCFG_STATIC = 2;
    localparam int EV_RCFG_DYN    = 3;
    localparam int EV_PORT_OPEN   = 4;
    localparam int EV_SW_MEAS     = 5;
    localparam int EV_PWR_OFF     = 6;

    typedef enum logic [1:0] {
        TS_OFF    = 2'd0,
        TS_BOOT   = 2'd1,
        TS_OPER   = 2'd2,
        TS_LOCKED = 2'd3
    } trust_state_e;

    typedef struct packed {
        logic boot_set;
        logic static_ext;
        logic recon_set;
        logic sw_ext;
        logic clear_all;
    } meas_ctl_t;
endpackage

// File: rtl/trust_mix.sv
// Combinational extend function: y = ((a rotl ROT) ^ d) + MIX_K.
// It stands in for a real hash. Assumes 0 < ROT < DW.
module trust_mix #(
    parameter int             DW    = 32,
    parameter int             ROT   = 5,
    parameter logic [DW-1:0]  MIX_K = 32'h9E3779B9
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] y
);
    logic [DW-1:0] rot_a;

    // Rotate the old value left, then fold in the digest and the constant.
    always_comb begin
        rot_a = {a[DW-1-ROT:0], a[DW-1:DW-ROT]};
        y     = (rot_a ^ d) + MIX_K;
    end
endmodule

// File: rtl/trust_fsm.sv
// Trust state machine. Decodes the one-hot event pulse against the current
// state and issues measurement strobes and an error flag.
// Assumes events are single-cycle pulses; a zero code means idle.
module trust_fsm
    import trust_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_code,
    input  logic               evt_certified,
    output trust_state_e       state_q,
    output meas_ctl_t          ctl,
    output logic               evt_err
);
    trust_state_e state_d;
    logic         single;

    // Exactly one event bit is set.
    always_comb single = (evt_code != '0) &&
                         ((evt_code & (evt_code - NUM_EVT'(1))) == '0);

    // Next state, strobes and error decode.
    always_comb begin
        state_d = state_q;
        ctl     = '0;
        evt_err = 1'b0;
        if ((evt_code != '0) && !single) begin
            evt_err = 1'b1;
        end else if (single) begin
            if (evt_code[EV_PWR_OFF]) begin
                state_d       = TS_OFF;
                ctl.clear_all = 1'b1;
            end else begin
                case (state_q)
                    TS_OFF: begin
                        if (evt_code[EV_PWR_ON]) state_d = TS_BOOT;
                        else                     evt_err = 1'b1;
                    end
                    TS_BOOT: begin
                        if (evt_code[EV_LOADED]) begin
                            state_d      = TS_OPER;
                            ctl.boot_set = 1'b1;
                        end else begin
                            evt_err = 1'b1;
                        end
                    end
                    TS_OPER: begin
                        if (evt_code[EV_RCFG_STATIC]) begin
                            if (evt_certified) ctl.static_ext = 1'b1;
                            else               state_d        = TS_LOCKED;
                        end else if (evt_code[EV_RCFG_DYN]) begin
                            ctl.recon_set = 1'b1;
                        end else if (evt_code[EV_PORT_OPEN]) begin
                            state_d = TS_LOCKED;
                        end else if (evt_code[EV_SW_MEAS]) begin
                            ctl.sw_ext = 1'b1;
                        end else begin
                            evt_err = 1'b1;
                        end
                    end
                    default: evt_err = 1'b1;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_OFF;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/trust_regs.sv
// Measurement storage: the accumulating static register, the overwritten
// reconfigurable register and the bank of platform registers. It acts only
// on strobes from the state machine. Assumes NPCR is a power of two, at least 2.
module trust_regs
    import trust_pkg::*;
#(
    parameter int             DW    = 32,
    parameter int             NPCR  = 4,
    parameter int             ROT   = 5,
    parameter logic [DW-1:0]  MIX_K = 32'h9E3779B9,
    localparam int            PSW   = $clog2(NPCR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  meas_ctl_t       ctl,
    input  logic [DW-1:0]   evt_digest,
    input  logic [PSW-1:0]  evt_pcr_sel,
    input  logic [PSW-1:0]  att_pcr_sel,
    output logic [DW-1:0]   static_q,
    output logic [DW-1:0]   recon_q,
    output logic [DW-1:0]   pcr_rd
);
    logic [DW-1:0] static_src;
    logic [DW-1:0] static_mix;
    logic [DW-1:0] pcr_q   [NPCR];
    logic [DW-1:0] pcr_mix [NPCR];

    // Boot starts the static chain from zero; later extends chain onward.
    always_comb static_src = ctl.boot_set ? '0 : static_q;

    trust_mix #(.DW(DW), .ROT(ROT), .MIX_K(MIX_K)) u_static_mix (
        .a (static_src),
        .d (evt_digest),
        .y (static_mix)
    );

    // Static-region register: cleared, seeded at boot, extended on certified change.
    always_ff @(posedge clk) begin
        if (!rst_n)                            static_q <= '0;
        else if (ctl.clear_all)                static_q <= '0;
        else if (ctl.boot_set || ctl.static_ext) static_q <= static_mix;
    end

    // Reconfigurable-region register: overwritten, never accumulated.
    always_ff @(posedge clk) begin
        if (!rst_n)                             recon_q <= '0;
        else if (ctl.clear_all)                 recon_q <= '0;
        else if (ctl.boot_set || ctl.recon_set) recon_q <= evt_digest;
    end

    for (genvar g = 0; g < NPCR; g++) begin : g_pcr
        trust_mix #(.DW(DW), .ROT(ROT), .MIX_K(MIX_K)) u_pcr_mix (
            .a (pcr_q[g]),
            .d (evt_digest),
            .y (pcr_mix[g])
        );

        // Platform register g: cleared on boot or region change, extended when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pcr_q[g] <= '0;
            else if (ctl.clear_all || ctl.boot_set || ctl.recon_set)
                pcr_q[g] <= '0;
            else if (ctl.sw_ext && (evt_pcr_sel == PSW'(g)))
                pcr_q[g] <= pcr_mix[g];
        end
    end

    // Read port for attestation.
    always_comb pcr_rd = pcr_q[att_pcr_sel];
endmodule

// File: rtl/trust_state_ctrl.sv
// Top of the trust-state controller. Combines the state machine, the
// measurement storage, a saturating error counter and the attestation gate.
// Assumes events are pre-hashed digests with one-cycle pulses.
module trust_state_ctrl
    import trust_pkg::*;
#(
    parameter int             DW    = 32,
    parameter int             NPCR  = 4,
    parameter int             EW    = 8,
    parameter int             ROT   = 5,
    parameter logic [DW-1:0]  MIX_K = 32'h9E3779B9,
    localparam int            PSW   = $clog2(NPCR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_code,
    input  logic               evt_certified,
    input  logic [DW-1:0]      evt_digest,
    input  logic [PSW-1:0]     evt_pcr_sel,
    input  logic [PSW-1:0]     att_pcr_sel,
    output logic               tpm_en,
    output logic [1:0]         trust_state,
    output logic               att_valid,
    output logic [DW-1:0]      att_static,
    output logic [DW-1:0]      att_recon,
    output logic [DW-1:0]      att_pcr,
    output logic [EW-1:0]      err_count
);
    trust_state_e  state_q;
    meas_ctl_t     ctl;
    logic          evt_err;
    logic [DW-1:0] static_q;
    logic [DW-1:0] recon_q;
    logic [DW-1:0] pcr_rd;

    trust_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_code      (evt_code),
        .evt_certified (evt_certified),
        .state_q       (state_q),
        .ctl           (ctl),
        .evt_err       (evt_err)
    );

    trust_regs #(.DW(DW), .NPCR(NPCR), .ROT(ROT), .MIX_K(MIX_K)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .evt_digest  (evt_digest),
        .evt_pcr_sel (evt_pcr_sel),
        .att_pcr_sel (att_pcr_sel),
        .static_q    (static_q),
        .recon_q     (recon_q),
        .pcr_rd      (pcr_rd)
    );

    // Saturating count of inapplicable events.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_count <= '0;
        else if (evt_err && (err_count != '1)) err_count <= err_count + EW'(1);
    end

    // Trust flag and gated attestation outputs.
    always_comb begin
        tpm_en      = (state_q == TS_OPER);
        trust_state = state_q;
        att_valid   = tpm_en;
        att_static  = tpm_en ? static_q : '0;
        att_recon   = tpm_en ? recon_q  : '0;
        att_pcr     = tpm_en ? pcr_rd   : '0;
    end
endmodule

// File: rtl/trust_state_ctrl_chk.sv
// Assertion checker for trust_state_ctrl, attached by bind. It sees only the ports.
module trust_state_ctrl_chk
    import trust_pkg::*;
#(
    parameter int DW = 32,
    parameter int EW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_code,
    input logic               evt_certified,
    input logic               tpm_en,
    input logic [1:0]         trust_state,
    input logic               att_valid,
    input logic [DW-1:0]      att_static,
    input logic [DW-1:0]      att_recon,
    input logic [DW-1:0]      att_pcr,
    input logic [EW-1:0]      err_count
);
    localparam logic [NUM_EVT-1:0] C_PON  = NUM_EVT'(1) << EV_PWR_ON;
    localparam logic [NUM_EVT-1:0] C_STA  = NUM_EVT'(1) << EV_RCFG_STATIC;
    localparam logic [NUM_EVT-1:0] C_PORT = NUM_EVT'(1) << EV_PORT_OPEN;
    localparam logic [NUM_EVT-1:0] C_POFF = NUM_EVT'(1) << EV_PWR_OFF;

    p_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trust_state == 2'd0 && evt_code == C_PON) |=> (trust_state == 2'd1));

    p_uncert_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trust_state == 2'd2 && evt_code == C_STA && !evt_certified) |=> (trust_state == 2'd3 && !tpm_en));

    p_port_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trust_state == 2'd2 && evt_code == C_PORT) |=> (trust_state == 2'd3));

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trust_state == 2'd3 && evt_code != C_POFF) |=> (trust_state == 2'd3));

    p_poweroff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_code == C_POFF) |=> (trust_state == 2'd0 && !att_valid));

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !att_valid |-> (att_static == '0 && att_recon == '0 && att_pcr == '0 && !tpm_en));

    p_err_mono_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_count >= $past(err_count)));
endmodule

bind trust_state_ctrl trust_state_ctrl_chk #(.DW(DW), .EW(EW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_code      (evt_code),
    .evt_certified (evt_certified),
    .tpm_en        (tpm_en),
    .trust_state   (trust_state),
    .att_valid     (att_valid),
    .att_static    (att_static),
    .att_recon     (att_recon),
    .att_pcr       (att_pcr),
    .err_count     (err_count)
);

// File: tb/test_trust_state_ctrl.sv
// Bench for trust_state_ctrl: a vector table walked by one loop, then directed tests.
module test_trust_state_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_code = '0;
    logic        evt_certified = 1'b0;
    logic [31:0] evt_digest = '0;
    logic [1:0]  evt_pcr_sel = '0;
    logic [1:0]  att_pcr_sel = '0;
    logic        tpm_en, att_valid;
    logic [1:0]  trust_state;
    logic [31:0] att_static, att_recon, att_pcr;
    logic [7:0]  err_count;

    int nchk = 0;
    int nerr = 0;

    // Bench model of the requirements.
    int          m_st = 0;
    int          m_err = 0;
    logic [31:0] m_static = '0;
    logic [31:0] m_recon = '0;
    logic [31:0] m_pcr [4] = '{default: '0};

    always #5 clk = ~clk;

    trust_state_ctrl i_trust_state_ctrl (
        .clk (clk), .rst_n (rst_n), .evt_code (evt_code),
        .evt_certified (evt_certified), .evt_digest (evt_digest),
        .evt_pcr_sel (evt_pcr_sel), .att_pcr_sel (att_pcr_sel),
        .tpm_en (tpm_en), .trust_state (trust_state), .att_valid (att_valid),
        .att_static (att_static), .att_recon (att_recon), .att_pcr (att_pcr),
        .err_count (err_count)
    );

    localparam logic [6:0] PON = 7'h01, LDD = 7'h02, STA = 7'h04, DYN = 7'h08,
                           PRT = 7'h10, SWM = 7'h20, POF = 7'h40;

    // Fields: [51:45] code, [44] cert, [43:12] digest, [11:10] sel, [9:8] state, [7:0] err
    localparam int NV = 22;
    localparam logic [51:0] VECS [NV] = '{
        {PON, 1'b0, 32'h0000_0000, 2'd0, 2'd1, 8'd0},   // R2 boot
        {SWM, 1'b0, 32'h0000_0001, 2'd0, 2'd1, 8'd1},   // R11 not applicable while booting
        {LDD, 1'b0, 32'hA0A0_0001, 2'd0, 2'd2, 8'd1},   // R2 load complete
        {SWM, 1'b0, 32'h0000_0011, 2'd1, 2'd2, 8'd1},   // R8
        {SWM, 1'b0, 32'h0000_0022, 2'd1, 2'd2, 8'd1},   // R8 chain
        {SWM, 1'b0, 32'h0000_0033, 2'd3, 2'd2, 8'd1},   // R8 other index
        {STA, 1'b1, 32'h5555_0000, 2'd0, 2'd2, 8'd1},   // R3
        {STA, 1'b1, 32'h6666_0000, 2'd0, 2'd2, 8'd1},   // R3 accumulates
        {DYN, 1'b0, 32'h7777_7777, 2'd0, 2'd2, 8'd1},   // R4
        {DYN, 1'b0, 32'h8888_8888, 2'd0, 2'd2, 8'd1},   // R4 overwrite
        {SWM, 1'b0, 32'h0000_0099, 2'd0, 2'd2, 8'd1},   // R8
        {LDD, 1'b0, 32'hDEAD_BEEF, 2'd0, 2'd2, 8'd2},   // R11
        {7'h28, 1'b0, 32'h1234_5678, 2'd2, 2'd2, 8'd3}, // R11 multi-bit
        {STA, 1'b0, 32'hBAD0_0000, 2'd0, 2'd3, 8'd3},   // R5
        {DYN, 1'b0, 32'h0000_0777, 2'd0, 2'd3, 8'd4},   // R7
        {PON, 1'b0, 32'h0000_0000, 2'd0, 2'd3, 8'd5},   // R7
        {POF, 1'b0, 32'h0000_0000, 2'd0, 2'd0, 8'd5},   // R9
        {POF, 1'b0, 32'h0000_0000, 2'd0, 2'd0, 8'd5},   // R9 in empty state
        {PON, 1'b0, 32'h0000_0000, 2'd0, 2'd1, 8'd5},   // R2
        {LDD, 1'b0, 32'h0000_1234, 2'd0, 2'd2, 8'd5},   // R2
        {PRT, 1'b0, 32'h0000_0000, 2'd0, 2'd3, 8'd5},   // R6
        {POF, 1'b0, 32'h0000_0000, 2'd0, 2'd0, 8'd5}    // R9
    };

    function automatic logic [31:0] hmix(logic [31:0] a, logic [31:0] d);
        return ({a[26:0], a[31:27]} ^ d) + 32'h9E3779B9;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update from the requirements for one event.
    task automatic model(logic [6:0] c, logic cert, logic [31:0] d, logic [1:0] s);
        bit ok = 1'b0;
        if (c == 7'h00) return;
        if ((c & (c - 7'd1)) != 7'h00) ok = 1'b0;
        else if (c == POF) begin
            ok = 1'b1; m_st = 0; m_static = '0; m_recon = '0;
            for (int i = 0; i < 4; i++) m_pcr[i] = '0;
        end else if (m_st == 0 && c == PON) begin ok = 1'b1; m_st = 1; end
        else if (m_st == 1 && c == LDD) begin
            ok = 1'b1; m_st = 2; m_static = hmix('0, d); m_recon = d;
            for (int i = 0; i < 4; i++) m_pcr[i] = '0;
        end else if (m_st == 2) begin
            ok = 1'b1;
            if (c == STA && cert) m_static = hmix(m_static, d);
            else if (c == STA) m_st = 3;
            else if (c == PRT) m_st = 3;
            else if (c == DYN) begin
                m_recon = d;
                for (int i = 0; i < 4; i++) m_pcr[i] = '0;
            end else if (c == SWM) m_pcr[s] = hmix(m_pcr[s], d);
            else ok = 1'b0;
        end
        if (!ok && m_err < 255) m_err++;
    endtask

    task automatic fire(logic [6:0] c, logic cert, logic [31:0] d, logic [1:0] s);
        @(negedge clk);
        evt_code = c; evt_certified = cert; evt_digest = d; evt_pcr_sel = s;
        @(negedge clk);
        evt_code = '0; evt_certified = 1'b0; evt_digest = '0;
        model(c, cert, d, s);
    endtask

    // Compare every observable output with the model.
    task automatic check_all(string tag);
        check({tag, " R1/R2 state"}, 32'(trust_state), 32'(m_st));
        check({tag, " R10 tpm_en"}, 32'(tpm_en), 32'(m_st == 2));
        check({tag, " R10 att_valid"}, 32'(att_valid), 32'(m_st == 2));
        check({tag, " R11 err_count"}, 32'(err_count), 32'(m_err));
        check({tag, " R3 static"}, att_static, (m_st == 2) ? m_static : '0);
        check({tag, " R4 recon"}, att_recon, (m_st == 2) ? m_recon : '0);
        for (int i = 0; i < 4; i++) begin
            att_pcr_sel = 2'(i);
            #1;
            check({tag, " R8 pcr"}, att_pcr, (m_st == 2) ? m_pcr[i] : '0);
        end
        att_pcr_sel = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_all("reset R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("after reset R1");

        for (int v = 0; v < NV; v++) begin
            fire(VECS[v][51:45], VECS[v][44], VECS[v][43:12], VECS[v][11:10]);
            check("table state", 32'(trust_state), 32'(VECS[v][9:8]));
            check("table R11 err", 32'(err_count), 32'(VECS[v][7:0]));
            check_all("table");
        end

        // R9: power-off while booting.
        fire(PON, 1'b0, '0, 2'd0);
        fire(POF, 1'b0, '0, 2'd0);
        check_all("poweroff boot R9");

        // R1: reset in the middle of operation.
        fire(PON, 1'b0, '0, 2'd0);
        fire(LDD, 1'b0, 32'hCAFE_0001, 2'd0);
        fire(SWM, 1'b0, 32'h0000_0042, 2'd2);
        check_all("before mid reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_st = 0; m_err = 0; m_static = '0; m_recon = '0;
        for (int i = 0; i < 4; i++) m_pcr[i] = '0;
        check_all("mid reset R1");

        // R11: the counter saturates at 255.
        for (int k = 0; k < 260; k++) fire(LDD, 1'b0, 32'h1, 2'd0);
        check("saturate R11", 32'(err_count), 32'd255);
        check_all("saturate R11");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule